// File: doc/BRIEF.md
# PCI Target with DRAM Address Window

This block is a simplified 32-bit PCI target that sits in front of an on-chip memory. In the address phase it takes the address from the AD lines and the command from C/BE#. It claims the transaction only when two things hold: the command is one of six supported codes, and the address falls inside a DRAM window set by a base and a mask. When it claims a transaction it drives DEVSEL# and TRDY# and runs one data phase or a burst of them. In the data phases it uses C/BE# as active-low byte enables.

Each completed data phase becomes one access on a plain internal memory port. That port has an address, write data, byte enables, a write strobe and asynchronously read data. On reads the target returns even parity one clock late. On writes it checks the parity supplied by the initiator, pulses PERR# two clocks after a phase whose parity is wrong, and raises a non-maskable interrupt request while PERR# is low and the interrupt enable is set. The surrounding register file supplies that enable from bit 17 of its control register.

Top module: `pci_dram_target`

## Requirements
- R1: A transaction is claimed only when FRAME# is sampled low while the target is idle, the command is supported and (AD & window mask) == window base. In the cycle after that address phase, devsel_n_o and trdy_n_o both go low. When the transaction is not claimed they stay high for the whole transaction.
- R2: The supported command codes on C/BE#[3:0] are 0010, 0011, 0110, 0111, 1010 and 1011. A code with bit 0 = 1 is a write and a code with bit 0 = 0 is a read. Any other code, for example 0000 or 1100, is not claimed even when its address is inside the window.
- R3: A data phase completes at a clock edge where trdy_n_o and irdy_n_i are both low. For a write, mem_we_o is high exactly in such a cycle, with mem_wdata_o = AD and mem_be_o = ~C/BE# (mem_be_o bit n enables byte lane n, bits 8n+7:8n).
- R4: mem_addr_o starts at the address-phase address and increases by 4 after each completed data phase. In a wait cycle (irdy_n_i high) the address holds and there is no write strobe.
- R5: A data phase that completes with frame_n_i high is the last one. In the next cycle devsel_n_o and trdy_n_o are high for one turnaround cycle. A new address phase is accepted in the cycle after that.
- R6: In a read data phase, ad_o equals mem_rdata_i and ad_oe_o is high. Outside read data phases ad_oe_o is low.
- R7: One clock after each read data-phase cycle, par_oe_o is high and par_o equals the XOR of ad_o and cbe_n_i from that cycle, which gives even parity.
- R8: For a completed write phase, the initiator's par_i from the next clock is compared with the even parity of that phase's AD and C/BE#. On a mismatch, perr_n_o is low for one cycle, two clocks after the data phase. When the parity is correct, perr_n_o stays high.
- R9: nmi_o is high exactly while perr_n_o is low and nmi_en_i (control register bit 17) is 1. It stays low when nmi_en_i is 0.
- R10: After reset, devsel_n_o, trdy_n_o and perr_n_o are high, and ad_oe_o, par_oe_o, mem_we_o and nmi_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_n_i | input | 1 | Transaction framing, active low |
| irdy_n_i | input | 1 | Initiator ready, active low |
| ad_i | input | 32 | Address/data from the bus |
| cbe_n_i | input | 4 | Command / byte enables, active low |
| par_i | input | 1 | Parity from the initiator for write data |
| win_base_i | input | 32 | DRAM window base |
| win_mask_i | input | 32 | DRAM window mask |
| nmi_en_i | input | 1 | Interrupt enable (control register bit 17) |
| ad_o | output | 32 | Read data to the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| devsel_n_o | output | 1 | Device select, active low |
| trdy_n_o | output | 1 | Target ready, active low |
| par_o | output | 1 | Even parity for read data |
| par_oe_o | output | 1 | Output enable for par_o |
| perr_n_o | output | 1 | Data parity error, active low |
| nmi_o | output | 1 | Non-maskable interrupt request |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_be_o | output | 4 | Memory byte enables, active high |
| mem_we_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data (asynchronous) |

## Verification
Single-phase transactions are run with every supported command, with two unsupported codes and with an address outside the window. These cases separate window decoding from command decoding, and reads from writes. Partial byte enables, together with a later read-back of the same words, show whether lane masking is correct. A write burst with an inserted wait state separates completed phases from stalled ones for address stepping and write strobing. Writes with good and with corrupted parity, run with the interrupt enable set and cleared, show whether the error report and the interrupt gating both follow the required timing.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  typedef enum logic [3:0] {
    CMD_IO_RD  = 4'b0010,
    CMD_IO_WR  = 4'b0011,
    CMD_MEM_RD = 4'b0110,
    CMD_MEM_WR = 4'b0111,
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } pci_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } tgt_state_e;

  function automatic logic cmd_supported(input logic [3:0] c);
    case (c)
      CMD_IO_RD, CMD_IO_WR, CMD_MEM_RD,
      CMD_MEM_WR, CMD_CFG_RD, CMD_CFG_WR: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
  import pci_tgt_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] ad_i,
  input  logic [3:0]    cbe_n_i,
  input  logic [DW-1:0] win_base_i,
  input  logic [DW-1:0] win_mask_i,
  output logic          claim_o,
  output logic          is_write_o
);
  logic win_hit;

  assign win_hit    = ((ad_i & win_mask_i) == win_base_i);
  assign claim_o    = win_hit && cmd_supported(cbe_n_i);
  assign is_write_o = cbe_n_i[0];
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm
  import pci_tgt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic          claim_i,
  input  logic          is_write_i,
  input  logic [AW-1:0] start_addr_i,
  output logic          in_data_o,
  output logic          wr_o,
  output logic          xfer_o,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] STEP = AW'(4);

  tgt_state_e    state_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;

  assign in_data_o = (state_q == ST_DATA);
  assign xfer_o    = in_data_o && !irdy_n_i;
  assign wr_o      = wr_q;
  assign addr_o    = addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wr_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (!frame_n_i) begin
          if (claim_i) begin
            state_q <= ST_DATA;
            addr_q  <= start_addr_i;
            wr_q    <= is_write_i;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        ST_DATA: if (xfer_o) begin
          addr_q <= addr_q + STEP;
          if (frame_n_i) state_q <= ST_TURN;
        end
        ST_TURN: state_q <= ST_IDLE;
        ST_SKIP: if (frame_n_i && irdy_n_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !frame_n_i) |=> (addr_q == $past(addr_q) + STEP));
  p_wait_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data_o && irdy_n_i) |=> (in_data_o && $stable(addr_q)));
  p_turnaround_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && frame_n_i) |=> (!in_data_o ##1 !in_data_o));
endmodule

// File: rtl/pci_tgt_parity.sv
module pci_tgt_parity #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] rd_data_i,
  input  logic          rd_oe_i,
  input  logic [DW-1:0] ad_i,
  input  logic [3:0]    cbe_n_i,
  input  logic          par_i,
  input  logic          wr_xfer_i,
  input  logic          nmi_en_i,
  output logic          par_o,
  output logic          par_oe_o,
  output logic          perr_n_o,
  output logic          nmi_o
);
  logic par_q, par_oe_q;
  logic chk_pend_q, calc_q, perr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_q      <= 1'b0;
      par_oe_q   <= 1'b0;
      chk_pend_q <= 1'b0;
      calc_q     <= 1'b0;
      perr_q     <= 1'b0;
    end else begin
      par_q      <= ^{rd_data_i, cbe_n_i};
      par_oe_q   <= rd_oe_i;
      chk_pend_q <= wr_xfer_i;
      calc_q     <= ^{ad_i, cbe_n_i};
      perr_q     <= chk_pend_q && (calc_q != par_i);
    end
  end

  assign par_o    = par_q;
  assign par_oe_o = par_oe_q;
  assign perr_n_o = !perr_q;
  assign nmi_o    = perr_q && nmi_en_i;

  p_perr_after_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !perr_n_o |-> $past(chk_pend_q));
  p_nmi_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_o |-> (!perr_n_o && nmi_en_i));
  p_par_follows_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_oe_i |=> par_oe_o);
endmodule

// File: rtl/pci_dram_target.sv
module pci_dram_target
  import pci_tgt_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_n_i,
  input  logic          irdy_n_i,
  input  logic [31:0]   ad_i,
  input  logic [3:0]    cbe_n_i,
  input  logic          par_i,
  input  logic [31:0]   win_base_i,
  input  logic [31:0]   win_mask_i,
  input  logic          nmi_en_i,
  output logic [31:0]   ad_o,
  output logic          ad_oe_o,
  output logic          devsel_n_o,
  output logic          trdy_n_o,
  output logic          par_o,
  output logic          par_oe_o,
  output logic          perr_n_o,
  output logic          nmi_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  output logic [3:0]    mem_be_o,
  output logic          mem_we_o,
  input  logic [31:0]   mem_rdata_i
);
  localparam int DW = 32;

  logic claim, is_write, in_data, wr, xfer;

  pci_tgt_decode #(.DW(DW)) u_decode (
    .ad_i       (ad_i),
    .cbe_n_i    (cbe_n_i),
    .win_base_i (win_base_i),
    .win_mask_i (win_mask_i),
    .claim_o    (claim),
    .is_write_o (is_write)
  );

  pci_tgt_fsm #(.AW(AW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_n_i    (frame_n_i),
    .irdy_n_i     (irdy_n_i),
    .claim_i      (claim),
    .is_write_i   (is_write),
    .start_addr_i (ad_i[AW-1:0]),
    .in_data_o    (in_data),
    .wr_o         (wr),
    .xfer_o       (xfer),
    .addr_o       (mem_addr_o)
  );

  assign devsel_n_o  = !in_data;
  assign trdy_n_o    = !in_data;
  assign ad_o        = mem_rdata_i;
  assign ad_oe_o     = in_data && !wr;
  assign mem_we_o    = xfer && wr;
  assign mem_wdata_o = ad_i;
  assign mem_be_o    = ~cbe_n_i;

  pci_tgt_parity #(.DW(DW)) u_parity (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_data_i (ad_o),
    .rd_oe_i   (ad_oe_o),
    .ad_i      (ad_i),
    .cbe_n_i   (cbe_n_i),
    .par_i     (par_i),
    .wr_xfer_i (mem_we_o),
    .nmi_en_i  (nmi_en_i),
    .par_o     (par_o),
    .par_oe_o  (par_oe_o),
    .perr_n_o  (perr_n_o),
    .nmi_o     (nmi_o)
  );

  p_trdy_in_claim_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_n_o |-> !devsel_n_o);
  p_we_on_handshake_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (!trdy_n_o && !irdy_n_i));
  p_no_claim_outside_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (devsel_n_o && !frame_n_i && ((ad_i & win_mask_i) != win_base_i)) |=> devsel_n_o);
endmodule

// File: tb/tb_pci_dram_target.sv
`timescale 1ns/1ps
module tb_pci_dram_target;
  localparam int AW = 16;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] MASK = 32'hFFFF_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_n = 1'b1, irdy_n = 1'b1, par_in = 1'b0, nmi_en = 1'b1;
  logic [31:0]   ad = '0;
  logic [3:0]    cbe_n = 4'hF;
  logic [31:0]   ad_o, mem_wdata, mem_rdata;
  logic          ad_oe, devsel_n, trdy_n, par_o, par_oe, perr_n, nmi, mem_we;
  logic [AW-1:0] mem_addr;
  logic [3:0]    mem_be;

  logic [31:0] mem  [16];
  logic [31:0] expm [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pci_dram_target #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n),
    .ad_i(ad), .cbe_n_i(cbe_n), .par_i(par_in), .win_base_i(BASE),
    .win_mask_i(MASK), .nmi_en_i(nmi_en), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .devsel_n_o(devsel_n), .trdy_n_o(trdy_n), .par_o(par_o), .par_oe_o(par_oe),
    .perr_n_o(perr_n), .nmi_o(nmi), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_be_o(mem_be), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[5:2]];
  always_ff @(posedge clk)
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[5:2]][8*b +: 8] <= mem_wdata[8*b +: 8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic epar(input logic [31:0] d, input logic [3:0] c);
    return ^{d, c};
  endfunction

  task automatic exp_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be_n);
    for (int b = 0; b < 4; b++)
      if (!be_n[b]) expm[a[5:2]][8*b +: 8] = d[8*b +: 8];
  endtask

  // {cmd, addr, data, be_n, bad_parity, expect_claim}
  localparam int NV = 9;
  localparam logic [73:0] VEC [NV] = '{
    {4'b0111, 32'h0001_0000, 32'hA5A5_0001, 4'b0000, 1'b0, 1'b1},
    {4'b0110, 32'h0001_0000, 32'h0,         4'b0000, 1'b0, 1'b1},
    {4'b0011, 32'h0001_0004, 32'h1234_5678, 4'b0101, 1'b1, 1'b1},
    {4'b1010, 32'h0001_0004, 32'h0,         4'b0000, 1'b0, 1'b1},
    {4'b0111, 32'h0002_0000, 32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0},
    {4'b0000, 32'h0001_0008, 32'hFFFF_FFFF, 4'b0000, 1'b0, 1'b0},
    {4'b1100, 32'h0001_0008, 32'h0,         4'b0000, 1'b0, 1'b0},
    {4'b1011, 32'h0001_000C, 32'hDEAD_BEEF, 4'b1110, 1'b0, 1'b1},
    {4'b0010, 32'h0001_000C, 32'h0,         4'b0000, 1'b0, 1'b1}
  };

  task automatic single(input logic [3:0] cmd, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] be_n, input bit bad, input bit claim);
    bit wr;
    logic [31:0] rexp;
    wr = cmd[0];
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = cmd;
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad = wr ? d : 32'h0; cbe_n = be_n;
    #1;
    chk(devsel_n == !claim, "R1/R2 devsel", 32'(devsel_n), 32'(!claim));
    chk(trdy_n == !claim, "R1 trdy", 32'(trdy_n), 32'(!claim));
    chk(mem_we == (claim && wr), "R3 we", 32'(mem_we), 32'(claim && wr));
    chk(ad_oe == (claim && !wr), "R6 ad_oe", 32'(ad_oe), 32'(claim && !wr));
    rexp = expm[a[5:2]];
    if (claim && wr) begin
      chk(mem_be == ~be_n, "R3 be", 32'(mem_be), 32'(~be_n));
      chk(mem_addr == a[AW-1:0], "R4 addr", 32'(mem_addr), 32'(a[AW-1:0]));
      chk(mem_wdata == d, "R3 wdata", mem_wdata, d);
    end
    if (claim && !wr) chk(ad_o == rexp, "R6 rdata", ad_o, rexp);
    @(negedge clk);
    irdy_n = 1'b1; par_in = epar(d, be_n) ^ bad;
    #1;
    chk(devsel_n && trdy_n, "R5 turnaround", 32'({devsel_n, trdy_n}), 32'h3);
    if (claim && !wr) begin
      chk(par_oe, "R7 par_oe", 32'(par_oe), 32'h1);
      chk(par_o == epar(rexp, be_n), "R7 par", 32'(par_o), 32'(epar(rexp, be_n)));
    end
    @(negedge clk);
    par_in = 1'b0;
    #1;
    chk(perr_n == !(claim && wr && bad), "R8 perr", 32'(perr_n), 32'(!(claim && wr && bad)));
    chk(nmi == (claim && wr && bad && nmi_en), "R9 nmi", 32'(nmi), 32'(claim && wr && bad && nmi_en));
    if (claim && wr) exp_write(a, d, be_n);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 32'h0101_0101 * i;
      expm[i] = 32'h0101_0101 * i;
    end
    #1;
    chk(devsel_n && trdy_n && perr_n, "R10 reset high", 32'({devsel_n, trdy_n, perr_n}), 32'h7);
    chk(!ad_oe && !par_oe && !mem_we && !nmi, "R10 reset low",
        32'({ad_oe, par_oe, mem_we, nmi}), 32'h0);
    #9 rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      single(VEC[v][73:70], VEC[v][69:38], VEC[v][37:6], VEC[v][5:2], VEC[v][1], VEC[v][0]);

    // R9: interrupt gated off while the parity error is still reported
    nmi_en = 1'b0;
    single(4'b0111, 32'h0001_0020, 32'h0F0F_0F0F, 4'b0000, 1'b1, 1'b1);
    nmi_en = 1'b1;

    // R4/R3: write burst of three phases with a wait cycle
    @(negedge clk);
    frame_n = 1'b0; ad = 32'h0001_0010; cbe_n = 4'b0111;
    @(negedge clk);
    irdy_n = 1'b0; ad = 32'h1111_1111; cbe_n = 4'b0000;
    #1 chk(mem_we && mem_addr == 16'h0010, "R4 burst p0", 32'(mem_addr), 32'h10);
    @(negedge clk);
    irdy_n = 1'b1; par_in = epar(32'h1111_1111, 4'b0000);
    #1 chk(!mem_we && mem_addr == 16'h0014 && !trdy_n, "R4 wait hold", 32'({mem_we, mem_addr}), 32'h14);
    @(negedge clk);
    irdy_n = 1'b0; ad = 32'h2222_2222; cbe_n = 4'b0000;
    #1 chk(mem_we && mem_addr == 16'h0014, "R4 burst p1", 32'(mem_addr), 32'h14);
    @(negedge clk);
    frame_n = 1'b1; ad = 32'h3333_3333; cbe_n = 4'b1100; par_in = epar(32'h2222_2222, 4'b0000);
    #1 chk(mem_addr == 16'h0018 && mem_be == 4'b0011, "R4 burst p2", 32'({mem_be, mem_addr}), 32'h3_0018);
    @(negedge clk);
    irdy_n = 1'b1; par_in = epar(32'h3333_3333, 4'b1100);
    #1 chk(devsel_n, "R5 burst end", 32'(devsel_n), 32'h1);
    @(negedge clk);
    #1 chk(perr_n, "R8 good parity burst", 32'(perr_n), 32'h1);
    exp_write(32'h10, 32'h1111_1111, 4'b0000);
    exp_write(32'h14, 32'h2222_2222, 4'b0000);
    exp_write(32'h18, 32'h3333_3333, 4'b1100);

    // R5/R6/R7: read burst issued right after the previous one, read-back of burst data
    frame_n = 1'b0; ad = 32'h0001_0014; cbe_n = 4'b0110;
    @(negedge clk);
    irdy_n = 1'b0; cbe_n = 4'b0000;
    #1 chk(ad_oe && ad_o == expm[5], "R6 burst r0", ad_o, expm[5]);
    @(negedge clk);
    frame_n = 1'b1; cbe_n = 4'b1010;
    #1 begin
      chk(par_o == epar(expm[5], 4'b0000), "R7 burst par0", 32'(par_o), 32'(epar(expm[5], 4'b0000)));
      chk(ad_o == expm[6], "R6 burst r1", ad_o, expm[6]);
    end
    @(negedge clk);
    irdy_n = 1'b1;
    #1 begin
      chk(par_oe && par_o == epar(expm[6], 4'b1010), "R7 burst par1", 32'(par_o), 32'(epar(expm[6], 4'b1010)));
      chk(!ad_oe && devsel_n, "R5 read end", 32'({ad_oe, devsel_n}), 32'h1);
    end
    @(negedge clk);
    #1 chk(!par_oe, "R7 par release", 32'(par_oe), 32'h0);

    // R3: lane-masked writes from the table read back correctly
    for (int w = 0; w < 8; w++)
      chk(mem[w] == expm[w], "R3 memory image", mem[w], expm[w]);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule